// File: doc/BRIEF.md
# Activity-Gated Variable-Resolution SAR Controller

This block is the digital sequencer of a charge-redistribution successive-approximation converter. On each sample it drives an offset-binary switch-control word to the capacitor array. It then reads back one comparator bit per bit cycle and builds the result one bit at a time, from the top bit down. The number of bit trials per sample is programmable from one to eight. The result is returned left-aligned in an 8-bit word and is announced by a one-cycle strobe.

Two operating modes are provided. In free-running mode every sample is converted. In activity-gated mode, each sample first spends one cycle comparing the input against a programmable spike threshold, placed on the same array. If the input does not reach that threshold, the controller parks the array at mid-scale for the slots the trials would have used and reports nothing. Either way, a gated sample takes the same number of slots. A per-sample activity flag lets downstream logic time-stamp detected events.

When the top-bit decision comes out low and more trials follow, the controller issues one flip pulse and moves the reference rails to their flip setting for that cycle. It also raises a swap level that exchanges the comparator's DAC inputs for the rest of the sample. The comparator bit is inverted internally while the swap is active, so the decisions stay correct.

Top module: `sar_activity_ctrl`

## Requirements
- R1: A synchronous active-low reset returns the controller to idle. After reset the DAC word is 0x80 (mid-scale), valid, flip and swap are 0, the rail select is 2'b01, the result is 0 and the activity flag is 0. The DAC word is also 0x80 whenever the controller is idle.
- R2: A resolution input of 1 to 8 sets the number of bit trials. A value of 0 acts as 1, and any value above 8 acts as 8.
- R3: A trial sets the bit under test in the DAC word, on top of the bits already decided. A comparator bit of 1 (input at or above the DAC word) keeps that bit. The result has its top N bits decided and every lower bit at 0.
- R4: With the mode input at 0 (free-running), every accepted start produces one conversion. Valid rises N clock edges after the edge that sampled start, and the activity flag is 1.
- R5: With the mode input at 1 (gated), the first slot drives the threshold code to the DAC. The threshold input uses bit 7 as the sign (1 means above mid-scale) and bits 6:2 as the magnitude; bits 1:0 are ignored. The code is 0x80 plus {0,bits 6:2,00} when the sign is 1, and 0x80 minus that value when the sign is 0.
- R6: In gated mode, a comparator bit of 1 in the detection slot starts the N trials. Valid rises N+1 edges after the start edge, and the activity flag is 1.
- R7: In gated mode, a comparator bit of 0 in the detection slot holds the DAC word at mid-scale for N further slots and then returns to idle. No valid is raised, the previous result is kept, and the activity flag is 0.
- R8: The flip pulse lasts one cycle and happens at most once per sample. It occurs in the slot after the top-bit decision, only when that decision is 0 and N is at least 2. During the pulse the rail select is 2'b10; at all other times it is 2'b01.
- R9: The swap output rises together with the flip pulse and stays high until the sample completes. While it is high, the controller inverts the comparator bit before using it.
- R10: Mode, resolution and threshold are taken only at the edge that accepts start. A start seen while a sample is in progress is ignored, and so are configuration changes made during a sample.
- R11: Valid is high for exactly one cycle per conversion. The result stays unchanged until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins a sample when the controller is idle |
| gated_mode_i | input | 1 | 0 selects free-running mode, 1 selects activity-gated mode |
| res_i | input | 4 | Requested number of bit trials |
| thr_i | input | 8 | Spike threshold as sign plus magnitude |
| cmp_i | input | 1 | Comparator decision for the current slot |
| dac_code_o | output | 8 | Offset-binary switch-control word to the array |
| rail_sel_o | output | 2 | Reference-rail select: 2'b01 normal, 2'b10 flip |
| flip_o | output | 1 | One-cycle flip pulse |
| swap_o | output | 1 | Exchanges the comparator's DAC inputs |
| result_o | output | 8 | Left-aligned conversion result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| active_o | output | 1 | Activity flag of the latest sample |

## Verification
Count the edge that samples start as edge 0. Then the DAC word for the first slot is visible after edge 0, a flip pulse after edge 1 (free-running) or edge 2 (gated), and valid after edge N (free-running) or edge N+1 (gated). The bench drives and samples on the falling edge. For each sample it records the index of the slot in which valid, flip and swap appear, and compares those indices with the expected values from the resolution and mode. After the sample window closes, it checks that the DAC word has returned to mid-scale and that the activity flag holds the expected value. The comparator model in the bench inverts its output while swap is high, so a controller that failed to undo the inversion would return a wrong code.

// File: rtl/sar_ctl_pkg.sv
// Shared types and constants of the SAR controller.
// Assumes: nothing beyond SystemVerilog 2017.
package sar_ctl_pkg;

    // Sequencer states: idle, threshold detection, bit trials, quiet (rejected sample)
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DETECT = 2'd1,
        ST_TRIAL  = 2'd2,
        ST_QUIET  = 2'd3
    } seq_state_t;

    // Reference-rail select encodings
    localparam logic [1:0] RAIL_NORMAL = 2'b01;
    localparam logic [1:0] RAIL_FLIP   = 2'b10;

endpackage

// File: rtl/sar_cfg_latch.sv
// Configuration front end: clamps the requested resolution and turns the
// sign-plus-magnitude threshold into an offset-binary DAC code. The clamped
// resolution is registered when a sample is accepted.
// Assumes: load_i is high only in the cycle in which a sample is accepted.
module sar_cfg_latch #(
    parameter int CODE_W  = 8,
    parameter int RES_W   = 4,
    parameter int THR_SIG = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [RES_W-1:0]  res_i,
    input  logic [CODE_W-1:0] thr_i,
    output logic [CODE_W-1:0] thr_code_o,
    output logic [RES_W-1:0]  nbits_q_o
);

    localparam int MAG_W = CODE_W - 1;
    localparam logic [MAG_W-1:0]  KEEP_MASK = {MAG_W{1'b1}} << (MAG_W - THR_SIG);
    localparam logic [CODE_W-1:0] MID       = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [RES_W-1:0]  RES_MAX   = RES_W'(CODE_W);
    localparam logic [RES_W-1:0]  RES_MIN   = RES_W'(1);

    logic [RES_W-1:0]  nbits_now;
    logic [CODE_W-1:0] mag_ext;

    // Clamp the requested number of trials into 1..CODE_W
    always_comb begin
        if (res_i < RES_MIN)
            nbits_now = RES_MIN;
        else if (res_i > RES_MAX)
            nbits_now = RES_MAX;
        else
            nbits_now = res_i;
    end

    // Keep only the significant magnitude bits and centre them on mid-scale
    always_comb begin
        mag_ext = {1'b0, thr_i[MAG_W-1:0] & KEEP_MASK};
        if (thr_i[CODE_W-1])
            thr_code_o = MID + mag_ext;
        else
            thr_code_o = MID - mag_ext;
    end

    // Hold the clamped resolution for the whole sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            nbits_q_o <= RES_MAX;
        else if (load_i)
            nbits_q_o <= nbits_now;
    end

endmodule

// File: rtl/sar_seq.sv
// Slot sequencer: walks idle -> (detect) -> trials or quiet -> idle, counts
// slots against the latched resolution and keeps the activity flag.
// Assumes: decide_i is the comparator bit already corrected for swap.
module sar_seq #(
    parameter int RES_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    gated_now_i,
    input  logic [RES_W-1:0]        nbits_q_i,
    input  logic                    decide_i,
    output sar_ctl_pkg::seq_state_t state_o,
    output logic [RES_W-1:0]        tidx_o,
    output logic                    take_o,
    output logic                    last_o,
    output logic                    active_o
);
    import sar_ctl_pkg::*;

    seq_state_t       state_q;
    logic [RES_W-1:0] tidx_q;
    logic             active_q;
    logic             slot_end;

    // Final slot of the trial or quiet phase
    assign slot_end = (tidx_q == nbits_q_i - RES_W'(1));
    assign take_o   = (state_q == ST_IDLE) && start_i;
    assign last_o   = (state_q == ST_TRIAL) && slot_end;
    assign state_o  = state_q;
    assign tidx_o   = tidx_q;
    assign active_o = active_q;

    // State, slot index and activity flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tidx_q   <= '0;
            active_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        tidx_q   <= '0;
                        active_q <= !gated_now_i;
                        state_q  <= gated_now_i ? ST_DETECT : ST_TRIAL;
                    end
                end
                ST_DETECT: begin
                    tidx_q   <= '0;
                    active_q <= decide_i;
                    state_q  <= decide_i ? ST_TRIAL : ST_QUIET;
                end
                ST_TRIAL, ST_QUIET: begin
                    if (slot_end) begin
                        tidx_q  <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        tidx_q  <= tidx_q + RES_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_approx_reg.sv
// Approximation register: holds the decided bits, forms the DAC word for
// each slot and publishes the left-aligned result with a one-cycle strobe.
// Assumes: tidx_i counts trials from 0 at the top bit; last_i marks the final trial.
module sar_approx_reg #(
    parameter int CODE_W = 8,
    parameter int RES_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  sar_ctl_pkg::seq_state_t state_i,
    input  logic [RES_W-1:0]        tidx_i,
    input  logic                    take_i,
    input  logic                    gated_now_i,
    input  logic [CODE_W-1:0]       thr_code_i,
    input  logic                    decide_i,
    input  logic                    last_i,
    output logic [CODE_W-1:0]       dac_o,
    output logic [CODE_W-1:0]       result_o,
    output logic                    valid_o
);
    import sar_ctl_pkg::*;

    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    logic [RES_W-1:0]  pos;
    logic              in_trial;
    logic [CODE_W-1:0] acc_q;
    logic [CODE_W-1:0] acc_next;
    logic [CODE_W-1:0] trial_bits;

    // Bit under test in the current trial
    assign pos      = RES_W'(CODE_W - 1) - tidx_i;
    assign in_trial = (state_i == ST_TRIAL);

    // Per-bit decision update and next-trial bit selection
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        assign acc_next[i] = (in_trial && pos == RES_W'(i)) ? decide_i : acc_q[i];
        if (i < CODE_W - 1) begin : g_nxt
            assign trial_bits[i] = (pos == RES_W'(i + 1));
        end else begin : g_top
            assign trial_bits[i] = 1'b0;
        end
    end

    // Accumulator, DAC word and result publication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            dac_o    <= MID;
            result_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (take_i) begin
                acc_q <= '0;
                dac_o <= gated_now_i ? thr_code_i : MID;
            end else begin
                case (state_i)
                    ST_TRIAL: begin
                        acc_q <= acc_next;
                        if (last_i) begin
                            result_o <= acc_next;
                            valid_o  <= 1'b1;
                            dac_o    <= MID;
                        end else begin
                            dac_o    <= acc_next | trial_bits;
                        end
                    end
                    default: dac_o <= MID;
                endcase
            end
        end
    end

endmodule

// File: rtl/sar_flip_ctl.sv
// Flip and swap control: one flip pulse with the rails in flip setting after a
// low top-bit decision, and a swap level held until the sample ends.
// Assumes: at least one further trial follows when nbits_q_i exceeds 1.
module sar_flip_ctl #(
    parameter int RES_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  sar_ctl_pkg::seq_state_t state_i,
    input  logic [RES_W-1:0]        tidx_i,
    input  logic [RES_W-1:0]        nbits_q_i,
    input  logic                    decide_i,
    input  logic                    take_i,
    input  logic                    last_i,
    output logic                    flip_o,
    output logic                    swap_o,
    output logic [1:0]              rail_sel_o
);
    import sar_ctl_pkg::*;

    logic flip_hit;

    // Low top-bit decision with more trials still to run
    assign flip_hit = (state_i == ST_TRIAL) && (tidx_i == '0) && !decide_i
                      && (nbits_q_i > RES_W'(1));

    // Flip pulse, rail select and swap level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flip_o     <= 1'b0;
            swap_o     <= 1'b0;
            rail_sel_o <= RAIL_NORMAL;
        end else begin
            flip_o     <= 1'b0;
            rail_sel_o <= RAIL_NORMAL;
            if (take_i) begin
                swap_o <= 1'b0;
            end else if (flip_hit) begin
                flip_o     <= 1'b1;
                swap_o     <= 1'b1;
                rail_sel_o <= RAIL_FLIP;
            end else if (last_i) begin
                swap_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sar_activity_ctrl.sv
// Top of the activity-gated variable-resolution SAR controller. Joins the
// configuration front end, slot sequencer, approximation register and flip
// control, and undoes the comparator inversion caused by swap.
// Assumes: cmp_i settles within the slot in which dac_code_o is presented.
module sar_activity_ctrl #(
    parameter int CODE_W  = 8,
    parameter int THR_SIG = 5,
    localparam int RES_W  = $clog2(CODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              gated_mode_i,
    input  logic [RES_W-1:0]  res_i,
    input  logic [CODE_W-1:0] thr_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic [1:0]        rail_sel_o,
    output logic              flip_o,
    output logic              swap_o,
    output logic [CODE_W-1:0] result_o,
    output logic              valid_o,
    output logic              active_o
);
    import sar_ctl_pkg::*;

    seq_state_t        seq_state;
    logic [RES_W-1:0]  tidx;
    logic [RES_W-1:0]  nbits_q;
    logic [CODE_W-1:0] thr_code;
    logic              take;
    logic              last;
    logic              decide;

    // Sign-corrected comparator decision
    assign decide = cmp_i ^ swap_o;

    sar_cfg_latch #(
        .CODE_W  (CODE_W),
        .RES_W   (RES_W),
        .THR_SIG (THR_SIG)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (take),
        .res_i      (res_i),
        .thr_i      (thr_i),
        .thr_code_o (thr_code),
        .nbits_q_o  (nbits_q)
    );

    sar_seq #(
        .RES_W (RES_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .gated_now_i (gated_mode_i),
        .nbits_q_i   (nbits_q),
        .decide_i    (decide),
        .state_o     (seq_state),
        .tidx_o      (tidx),
        .take_o      (take),
        .last_o      (last),
        .active_o    (active_o)
    );

    sar_approx_reg #(
        .CODE_W (CODE_W),
        .RES_W  (RES_W)
    ) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (seq_state),
        .tidx_i      (tidx),
        .take_i      (take),
        .gated_now_i (gated_mode_i),
        .thr_code_i  (thr_code),
        .decide_i    (decide),
        .last_i      (last),
        .dac_o       (dac_code_o),
        .result_o    (result_o),
        .valid_o     (valid_o)
    );

    sar_flip_ctl #(
        .RES_W (RES_W)
    ) u_flip (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (seq_state),
        .tidx_i     (tidx),
        .nbits_q_i  (nbits_q),
        .decide_i   (decide),
        .take_i     (take),
        .last_i     (last),
        .flip_o     (flip_o),
        .swap_o     (swap_o),
        .rail_sel_o (rail_sel_o)
    );

endmodule

// File: rtl/sar_activity_ctrl_chk.sv
// Property checker for the SAR controller, attached to the top by bind.
// Assumes: state_i and nbits_i are the sequencer state and latched resolution.
module sar_activity_ctrl_chk #(
    parameter int CODE_W = 8,
    parameter int RES_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  sar_ctl_pkg::seq_state_t state_i,
    input  logic [RES_W-1:0]        nbits_i,
    input  logic [CODE_W-1:0]       dac_i,
    input  logic                    flip_i,
    input  logic                    swap_i,
    input  logic [CODE_W-1:0]       result_i,
    input  logic                    valid_i
);
    import sar_ctl_pkg::*;

    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] low_mask;

    // Bits below the latched resolution
    assign low_mask = {CODE_W{1'b1}} >> nbits_i;

    a_r1_idle_midscale: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE) |-> (dac_i == MID));

    a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> ((result_i & low_mask) == '0));

    a_r7_quiet_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_QUIET) |-> (!valid_i && dac_i == MID));

    a_r8_flip_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        flip_i |=> !flip_i);

    a_r8_flip_in_trial: assert property (@(posedge clk) disable iff (!rst_n)
        flip_i |-> (state_i == ST_TRIAL && swap_i));

    a_r9_swap_rise_with_flip: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swap_i) |-> flip_i);

    a_r9_swap_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE) |-> !swap_i);

    a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> !valid_i);

endmodule

bind sar_activity_ctrl sar_activity_ctrl_chk #(
    .CODE_W (CODE_W),
    .RES_W  (RES_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_i  (seq_state),
    .nbits_i  (nbits_q),
    .dac_i    (dac_code_o),
    .flip_i   (flip_o),
    .swap_i   (swap_o),
    .result_i (result_o),
    .valid_i  (valid_o)
);

// File: tb/sim_sar_activity_ctrl.sv
// Directed bench for the SAR controller; comparator modelled from a held input level.
module sim_sar_activity_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       gated = 1'b0;
    logic [3:0] res = 4'd8;
    logic [7:0] thr = 8'h00;
    logic [7:0] vin = 8'h80;
    logic       cmp;
    logic [7:0] dac;
    logic [1:0] rail;
    logic       flip;
    logic       swap;
    logic [7:0] result;
    logic       valid;
    logic       active;

    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic [7:0] last_res = 8'h00;

    always #4 clk = ~clk;

    // Comparator: 1 when the input is at or above the DAC word, inverted by swap
    assign cmp = (vin >= dac) ^ swap;

    sar_activity_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .gated_mode_i (gated),
        .res_i        (res),
        .thr_i        (thr),
        .cmp_i        (cmp),
        .dac_code_o   (dac),
        .rail_sel_o   (rail),
        .flip_o       (flip),
        .swap_o       (swap),
        .result_o     (result),
        .valid_o      (valid),
        .active_o     (active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_thr(input logic [7:0] t);
        logic [7:0] m;
        m = {1'b0, t[6:2], 2'b00};
        return t[7] ? (8'h80 + m) : (8'h80 - m);
    endfunction

    task automatic check_idle(input string req);
        chk(dac == 8'h80, {req, " dac"}, dac, 8'h80);
        chk(valid == 1'b0 && flip == 1'b0 && swap == 1'b0, {req, " strobes"},
            {valid, flip, swap}, 0);
        chk(rail == 2'b01, {req, " rail"}, rail, 2'b01);
    endtask

    // R1: reset state
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        chk(result == 8'h00, "R1 result", result, 0);
        chk(active == 1'b0, "R1 active", active, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1: reset in the middle of a sample
    task automatic t_reset_mid;
        gated = 1'b0; res = 4'd8; vin = 8'h3C; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_idle("R1 mid-sample reset");
        chk(result == 8'h00 && active == 1'b0, "R1 mid-sample reset result", result, 0);
        last_res = 8'h00;
        repeat (2) @(negedge clk);
    endtask

    // One sample with independent expectations; disturb pokes start/config mid-sample
    task automatic run_sample(input bit g, input int r, input logic [7:0] t,
                              input logic [7:0] v, input bit disturb, input string tag);
        int         n;
        logic [7:0] tc;
        bit         pass;
        logic [7:0] er;
        bit         eflip;
        int         vcnt, vslot, fcnt, fslot, scnt, rail_bad;
        logic [7:0] got;
        n = (r < 1) ? 1 : ((r > 8) ? 8 : r);
        tc = exp_thr(t);
        pass = g ? (v >= tc) : 1'b1;
        er = v & (8'hFF << (8 - n));
        eflip = pass && (n >= 2) && (v < 8'h80);
        vcnt = 0; vslot = -1; fcnt = 0; fslot = -1; scnt = 0; rail_bad = 0; got = 8'h00;
        gated = g; res = 4'(r); thr = t; vin = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int s = 0; s <= n + 3; s++) begin
            if (s == 0) begin
                if (g) chk(dac == tc, {tag, " R5 detect code"}, dac, tc);
                else   chk(dac == 8'h80, {tag, " R4 first trial"}, dac, 8'h80);
            end
            if (valid) begin vcnt++; vslot = s; got = result; end
            if (flip) begin
                fcnt++; fslot = s;
                if (rail != 2'b10) rail_bad++;
            end else if (rail != 2'b01) begin
                rail_bad++;
            end
            if (swap) scnt++;
            if (disturb && s == 1) begin
                start = 1'b1; res = 4'd1; gated = ~g; thr = ~t;
            end
            if (disturb && s == 2) start = 1'b0;
            @(negedge clk);
        end
        if (pass) begin
            chk(vcnt == 1, {tag, " R4 R6 R11 valid count"}, vcnt, 1);
            chk(vslot == (g ? n + 1 : n), {tag, " R2 valid slot"}, vslot, g ? n + 1 : n);
            chk(got == er, {tag, " R3 result"}, got, er);
            last_res = er;
        end else begin
            chk(vcnt == 0, {tag, " R7 no valid"}, vcnt, 0);
        end
        chk(result == last_res, {tag, " R11 result held"}, result, last_res);
        chk(fcnt == int'(eflip), {tag, " R8 flip count"}, fcnt, int'(eflip));
        if (eflip) chk(fslot == (g ? 2 : 1), {tag, " R8 flip slot"}, fslot, g ? 2 : 1);
        chk(rail_bad == 0, {tag, " R8 rail select"}, rail_bad, 0);
        chk(scnt == (eflip ? n - 1 : 0), {tag, " R9 swap span"}, scnt, eflip ? n - 1 : 0);
        chk(active == pass, {tag, " R6 R7 activity"}, active, pass);
        chk(dac == 8'h80, {tag, " R1 idle midscale"}, dac, 8'h80);
    endtask

    initial begin
        t_reset();
        run_sample(1'b0, 8, 8'h00, 8'hA5, 1'b0, "R4 free 8b");
        run_sample(1'b0, 8, 8'h00, 8'h3C, 1'b0, "R9 free 8b low");
        run_sample(1'b0, 4, 8'h00, 8'h6B, 1'b0, "R2 free 4b");
        run_sample(1'b0, 1, 8'h00, 8'h40, 1'b0, "R8 free 1b low");
        run_sample(1'b0, 1, 8'h00, 8'hC0, 1'b0, "R2 free 1b high");
        run_sample(1'b0, 0, 8'h00, 8'hE7, 1'b0, "R2 res zero");
        run_sample(1'b0, 12, 8'h00, 8'h59, 1'b0, "R2 res over");
        run_sample(1'b1, 6, 8'hA0, 8'hB7, 1'b0, "R6 gated pass");
        run_sample(1'b1, 6, 8'hA0, 8'h90, 1'b0, "R7 gated reject");
        run_sample(1'b1, 8, 8'h83, 8'h80, 1'b0, "R5 low bits ignored pass");
        run_sample(1'b1, 8, 8'h83, 8'h7F, 1'b0, "R5 low bits ignored reject");
        run_sample(1'b1, 8, 8'h10, 8'h71, 1'b0, "R5 negative thr pass");
        run_sample(1'b1, 3, 8'h10, 8'h6F, 1'b0, "R7 negative thr reject");
        run_sample(1'b0, 5, 8'h00, 8'h5A, 1'b1, "R10 free disturbed");
        run_sample(1'b1, 7, 8'hB0, 8'hD3, 1'b1, "R10 gated disturbed");
        t_reset_mid();
        run_sample(1'b0, 8, 8'h00, 8'h01, 1'b0, "R3 after reset");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule